// File: doc/BRIEF.md
# Single-Wire Parity Chunk Framer

This block moves one chunk of seven or eight bits across a single shared line. It is either the sender or the receiver for one chunk, and which role it takes is chosen by a mode input at the moment a start strobe is accepted. A separate sequencer decides the order of chunks and the direction changes, and it calls the framer once per chunk.

Each chunk opens with its own synchronisation pulse. The line is held low for one bit period and then high for one clock. After that come the data bits, most significant first, and then an even-parity bit. The sender then holds the line low for one more bit period, so the next chunk's pulse again begins from a low level.

The receiver waits for the line to fall and then for it to rise. That rising edge gives it a fresh timing reference for every chunk. It then samples each bit near the middle of its period, recomputes the parity and reports any mismatch. The bit period `BIT_CYC` is given in clock cycles. At the default of 96 it matches a 6 µs bit at 16 MHz; other rates such as 4, 12, 24, 36 or 48 µs are a matter of changing `BIT_CYC`. The first half period is `BIT_CYC/2`, rounded down.

Top module: `swire_framer`

The controller has the following states:
- `ST_IDLE`
- `ST_TX_SYNC_LO`
- `ST_TX_SYNC_HI`
- `ST_TX_DATA`
- `ST_TX_PAR`
- `ST_TX_TAIL`
- `ST_RX_WAIT_LO`
- `ST_RX_WAIT_HI`
- `ST_RX_BITS`
- `ST_RX_DONE`

It makes the following transitions:

| From | To | Condition |
|---|---|---|
| `ST_IDLE` | `ST_TX_SYNC_LO` | `start` with `tx_mode` high |
| `ST_IDLE` | `ST_RX_WAIT_LO` | `start` with `tx_mode` low |
| `ST_TX_SYNC_LO` | `ST_TX_SYNC_HI` | after `BIT_CYC` cycles |
| `ST_TX_SYNC_HI` | `ST_TX_DATA` | after one cycle |
| `ST_TX_DATA` | `ST_TX_DATA` | at the end of each bit that is not the last |
| `ST_TX_DATA` | `ST_TX_PAR` | at the end of the last data bit |
| `ST_TX_PAR` | `ST_TX_TAIL` | after `BIT_CYC` cycles |
| `ST_TX_TAIL` | `ST_IDLE` | after `BIT_CYC` cycles, with `done` |
| `ST_RX_WAIT_LO` | `ST_RX_WAIT_HI` | the line reads low, or `TMO_BITS*BIT_CYC` cycles pass with the line high |
| `ST_RX_WAIT_HI` | `ST_RX_BITS` | the line reads high |
| `ST_RX_BITS` | `ST_RX_DONE` | the parity bit is sampled |
| `ST_RX_DONE` | `ST_IDLE` | after one cycle, with `done` |

## Requirements
- R1: `start` is taken only in `ST_IDLE`, and `tx_mode`, `wide` and `tx_data` are captured on that edge. A `start` pulse or any change to these inputs while a chunk is in progress does not alter the line, `done`, `rx_data` or `parity_err`.
- R2: In transmit mode the line is driven (`line_oe`=1) from the cycle after the accepting edge. It is low for `BIT_CYC` cycles and then high for exactly one cycle.
- R3: The data bits follow the sync pulse most significant first, each held for `BIT_CYC` cycles. With `wide`=1 the bits are `tx_data[7:0]`. With `wide`=0 they are `tx_data[6:0]`, starting with bit 6.
- R4: The data is followed by one parity bit held for `BIT_CYC` cycles. Its value is the XOR of the data bits sent, so the count of ones including parity is even.
- R5: After the parity bit the line is driven low for `BIT_CYC` cycles and then released.
- R6: In `ST_IDLE` and during a receive, `line_oe`=0 and `line_out`=1. These are also the reset values, together with `rx_data`=0, `parity_err`=0 and `done`=0.
- R7: In receive mode, a low level seen at a clock edge ends the wait for low. Bit timing is then referenced to the first later edge at which the line reads high.
- R8: The first sample is taken `BIT_CYC/2 + 1` edges after the reference edge. Further samples follow every `BIT_CYC` edges: 7 or 8 data samples, then one parity sample.
- R9: `done` is high in the cycle after the parity sample. `rx_data` and `parity_err` update only at that edge. `rx_data` holds the received bits right-aligned, with bit 7 zero when `wide`=0. `parity_err`=1 when the sampled parity differs from the XOR of the received bits.
- R10: `done` is a single-cycle pulse. In transmit mode it falls in the last cycle of the low tail.
- R11: If the line stays high for `TMO_BITS*BIT_CYC` edges in `ST_RX_WAIT_LO`, the receiver stops waiting for low. It then takes the next high edge as its timing reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| start | input | 1 | Begin one chunk when idle |
| tx_mode | input | 1 | 1 = send a chunk, 0 = receive a chunk |
| wide | input | 1 | 1 = `DATA_W` bits, 0 = `DATA_W`-1 bits |
| tx_data | input | DATA_W | Chunk to send |
| line_in | input | 1 | Level read from the shared line |
| line_out | output | 1 | Level to drive on the shared line |
| line_oe | output | 1 | Drive enable for the shared line |
| rx_data | output | DATA_W | Last chunk received, right-aligned |
| done | output | 1 | One-cycle pulse at the end of a chunk |
| parity_err | output | 1 | Parity mismatch on the last chunk received |

## Verification
The assertions check several properties on every cycle:
- A driven frame always opens low and always ends on a low level.
- The transmit `done` coincides with a low line.
- `done` never lasts more than one cycle.
- The released line reads high.
- `rx_data` and `parity_err` never move outside a `done` cycle.

Other behaviour can only be shown by the bench's scenarios, which compare every cycle against a reference model. These include:
- the exact bit order and per-bit duration in both widths;
- the parity value;
- the mid-bit sample points relative to the sync edge;
- the detection of a corrupted parity bit;
- the timeout path, where the line never falls;
- the fact that a stray start pulse or an input change in the middle of a chunk leaves the chunk untouched.

// File: rtl/swire_pkg.sv
`timescale 1ns/1ps
package swire_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TX_SYNC_LO,
        ST_TX_SYNC_HI,
        ST_TX_DATA,
        ST_TX_PAR,
        ST_TX_TAIL,
        ST_RX_WAIT_LO,
        ST_RX_WAIT_HI,
        ST_RX_BITS,
        ST_RX_DONE
    } swf_state_e;

endpackage

// File: rtl/swire_timer.sv
`timescale 1ns/1ps
// Down counter shared by every timed phase; load wins over decrement,
// decrement saturates at zero.
module swire_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/swire_shifter.sv
`timescale 1ns/1ps
// Shared shift register and parity accumulator for both directions.
module swire_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_tx,
    input  logic              wide,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              clr,
    input  logic              shift_tx,
    input  logic              shift_rx,
    input  logic              commit,
    input  logic              rx_bit,
    output logic              tx_bit,
    output logic              par_acc,
    output logic [DATA_W-1:0] rx_data,
    output logic              parity_err
);

    logic [DATA_W-1:0] sr;
    logic              acc;
    logic [DATA_W-1:0] load_word;

    // A short chunk is left-justified so the MSB always leaves first.
    always_comb begin
        if (wide) begin
            load_word = tx_word;
        end else begin
            load_word = {tx_word[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            acc <= 1'b0;
        end else if (ld_tx) begin
            sr  <= load_word;
            acc <= 1'b0;
        end else if (clr) begin
            sr  <= '0;
            acc <= 1'b0;
        end else if (shift_tx) begin
            sr  <= {sr[DATA_W-2:0], 1'b0};
            acc <= acc ^ sr[DATA_W-1];
        end else if (shift_rx) begin
            sr  <= {sr[DATA_W-2:0], rx_bit};
            acc <= acc ^ rx_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            parity_err <= 1'b0;
        end else if (commit) begin
            rx_data    <= sr;
            parity_err <= acc ^ rx_bit;
        end
    end

    assign tx_bit  = sr[DATA_W-1];
    assign par_acc = acc;

endmodule

// File: rtl/swire_ctrl.sv
`timescale 1ns/1ps
module swire_ctrl
    import swire_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int BIT_CYC  = 96,
    parameter int TMO_BITS = 5,
    parameter int CNT_W    = 9,
    parameter int IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tx_mode,
    input  logic             wide,
    input  logic             line_in,
    input  logic             tmr_zero,
    input  logic             tx_bit,
    input  logic             par_acc,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             tmr_dec,
    output logic             sh_ld_tx,
    output logic             sh_clr,
    output logic             sh_shift_tx,
    output logic             sh_shift_rx,
    output logic             sh_commit,
    output logic             line_out,
    output logic             line_oe,
    output logic             done
);

    localparam logic [CNT_W-1:0] LD_BIT  = CNT_W'(BIT_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HALF = CNT_W'(BIT_CYC / 2);
    localparam logic [CNT_W-1:0] LD_TMO  = CNT_W'(TMO_BITS * BIT_CYC - 1);
    localparam logic [IDX_W-1:0] FULL_N  = IDX_W'(DATA_W);

    swf_state_e       state, next_state;
    logic             wide_q;
    logic [IDX_W-1:0] bidx;
    logic [IDX_W-1:0] n_bits;

    assign n_bits = wide_q ? FULL_N : (FULL_N - 1'b1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= next_state;
        end
    end

    // Chunk width latch and bit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q <= 1'b1;
            bidx   <= '0;
        end else begin
            if ((state == ST_IDLE) && start) begin
                wide_q <= wide;
            end
            if (state == ST_TX_SYNC_HI) begin
                bidx <= n_bits - 1'b1;
            end else if ((state == ST_RX_WAIT_HI) && line_in) begin
                bidx <= n_bits;
            end else if (((state == ST_TX_DATA) || (state == ST_RX_BITS))
                         && tmr_zero && (bidx != '0)) begin
                bidx <= bidx - 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    next_state = tx_mode ? ST_TX_SYNC_LO : ST_RX_WAIT_LO;
                end
            end
            ST_TX_SYNC_LO: if (tmr_zero) next_state = ST_TX_SYNC_HI;
            ST_TX_SYNC_HI: next_state = ST_TX_DATA;
            ST_TX_DATA: begin
                if (tmr_zero && (bidx == '0)) next_state = ST_TX_PAR;
            end
            ST_TX_PAR:     if (tmr_zero) next_state = ST_TX_TAIL;
            ST_TX_TAIL:    if (tmr_zero) next_state = ST_IDLE;
            ST_RX_WAIT_LO: begin
                if (!line_in || tmr_zero) next_state = ST_RX_WAIT_HI;
            end
            ST_RX_WAIT_HI: if (line_in) next_state = ST_RX_BITS;
            ST_RX_BITS: begin
                if (tmr_zero && (bidx == '0)) next_state = ST_RX_DONE;
            end
            ST_RX_DONE:    next_state = ST_IDLE;
            default:       next_state = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        tmr_load    = 1'b0;
        tmr_val     = LD_BIT;
        tmr_dec     = 1'b0;
        sh_ld_tx    = 1'b0;
        sh_clr      = 1'b0;
        sh_shift_tx = 1'b0;
        sh_shift_rx = 1'b0;
        sh_commit   = 1'b0;
        line_oe     = 1'b0;
        line_out    = 1'b1;
        done        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    tmr_load = 1'b1;
                    if (tx_mode) begin
                        sh_ld_tx = 1'b1;
                    end else begin
                        tmr_val = LD_TMO;
                        sh_clr  = 1'b1;
                    end
                end
            end
            ST_TX_SYNC_LO: begin
                line_oe  = 1'b1;
                line_out = 1'b0;
                tmr_dec  = 1'b1;
            end
            ST_TX_SYNC_HI: begin
                line_oe  = 1'b1;
                line_out = 1'b1;
                tmr_load = 1'b1;
            end
            ST_TX_DATA: begin
                line_oe  = 1'b1;
                line_out = tx_bit;
                if (tmr_zero) begin
                    sh_shift_tx = 1'b1;
                    tmr_load    = 1'b1;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_TX_PAR: begin
                line_oe  = 1'b1;
                line_out = par_acc;
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_TX_TAIL: begin
                line_oe  = 1'b1;
                line_out = 1'b0;
                tmr_dec  = 1'b1;
                done     = tmr_zero;
            end
            ST_RX_WAIT_LO: begin
                tmr_dec = 1'b1;
            end
            ST_RX_WAIT_HI: begin
                if (line_in) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_HALF;
                end
            end
            ST_RX_BITS: begin
                if (tmr_zero) begin
                    if (bidx == '0) begin
                        sh_commit = 1'b1;
                    end else begin
                        sh_shift_rx = 1'b1;
                        tmr_load    = 1'b1;
                    end
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_RX_DONE: begin
                done = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/swire_framer.sv
`timescale 1ns/1ps
module swire_framer #(
    parameter int DATA_W   = 8,
    parameter int BIT_CYC  = 96,
    parameter int TMO_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tx_mode,
    input  logic              wide,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              line_in,
    output logic              line_out,
    output logic              line_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              done,
    output logic              parity_err
);

    localparam int CNT_W = $clog2(TMO_BITS * BIT_CYC);
    localparam int IDX_W = $clog2(DATA_W + 1);

    logic             tmr_load, tmr_dec, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_ld_tx, sh_clr, sh_shift_tx, sh_shift_rx, sh_commit;
    logic             tx_bit, par_acc;

    swire_ctrl #(
        .DATA_W  (DATA_W),
        .BIT_CYC (BIT_CYC),
        .TMO_BITS(TMO_BITS),
        .CNT_W   (CNT_W),
        .IDX_W   (IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .tx_mode    (tx_mode),
        .wide       (wide),
        .line_in    (line_in),
        .tmr_zero   (tmr_zero),
        .tx_bit     (tx_bit),
        .par_acc    (par_acc),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .tmr_dec    (tmr_dec),
        .sh_ld_tx   (sh_ld_tx),
        .sh_clr     (sh_clr),
        .sh_shift_tx(sh_shift_tx),
        .sh_shift_rx(sh_shift_rx),
        .sh_commit  (sh_commit),
        .line_out   (line_out),
        .line_oe    (line_oe),
        .done       (done)
    );

    swire_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .dec     (tmr_dec),
        .zero    (tmr_zero)
    );

    swire_shifter #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_tx     (sh_ld_tx),
        .wide      (wide),
        .tx_word   (tx_data),
        .clr       (sh_clr),
        .shift_tx  (sh_shift_tx),
        .shift_rx  (sh_shift_rx),
        .commit    (sh_commit),
        .rx_bit    (line_in),
        .tx_bit    (tx_bit),
        .par_acc   (par_acc),
        .rx_data   (rx_data),
        .parity_err(parity_err)
    );

endmodule

// File: rtl/swire_framer_chk.sv
`timescale 1ns/1ps
module swire_framer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_out,
    input logic              line_oe,
    input logic [DATA_W-1:0] rx_data,
    input logic              done,
    input logic              parity_err
);

    // R2: a driven frame opens with the low half of the sync pulse
    a_r2_sync_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> !line_out);

    // R5: the last driven cycle before release is low
    a_r5_tail_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe) |-> !$past(line_out));

    // R10: transmit completion coincides with the low tail
    a_r10_done_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (done && line_oe) |-> !line_out);

    // R10: completion strobe lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: received word moves only with completion
    a_r9_rx_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_data != $past(rx_data)) |-> done);

    // R9: parity flag moves only with completion
    a_r9_perr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err != $past(parity_err)) |-> done);

    // R6: an undriven line is presented high
    a_r6_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> line_out);

endmodule

bind swire_framer swire_framer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_out  (line_out),
    .line_oe   (line_oe),
    .rx_data   (rx_data),
    .done      (done),
    .parity_err(parity_err)
);

// File: tb/swire_framer_bench.sv
`timescale 1ns/1ps
module swire_framer_bench;

    localparam int DATA_W   = 8;
    localparam int BIT_CYC  = 9;
    localparam int TMO_BITS = 5;
    localparam int HALF     = BIT_CYC / 2;
    localparam int TMO      = TMO_BITS * BIT_CYC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       tx_mode = 1'b0;
    logic       wide = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       line_in = 1'b1;
    logic       line_out, line_oe, done, parity_err;
    logic [7:0] rx_data;

    swire_framer #(
        .DATA_W  (DATA_W),
        .BIT_CYC (BIT_CYC),
        .TMO_BITS(TMO_BITS)
    ) u_swire_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tx_mode   (tx_mode),
        .wide      (wide),
        .tx_data   (tx_data),
        .line_in   (line_in),
        .line_out  (line_out),
        .line_oe   (line_oe),
        .rx_data   (rx_data),
        .done      (done),
        .parity_err(parity_err)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // Expected per-cycle outputs, one entry per clock after the start edge
    bit         q_oe[$];
    bit         q_out[$];
    bit         q_dn[$];
    bit         q_up[$];
    logic [7:0] q_rd[$];
    bit         q_pe[$];
    string      q_tag[$];
    bit         l_q[$];
    logic [7:0] e_rd = 8'h00;
    bit         e_pe = 1'b0;

    task automatic check(string tg, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tg, what, act, exp, $time);
        end
    endtask

    task automatic push(bit oe, bit o, bit dn, bit up, logic [7:0] rd, bit pe, string tg);
        q_oe.push_back(oe);
        q_out.push_back(o);
        q_dn.push_back(dn);
        q_up.push_back(up);
        q_rd.push_back(rd);
        q_pe.push_back(pe);
        q_tag.push_back(tg);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Line driver: entry j is visible at edge S+1+j
    always @(posedge clk) begin
        #1;
        if (l_q.size() > 0) line_in = l_q.pop_front();
        else line_in = 1'b1;
    end

    // Per-cycle comparison against the model, away from the edge
    always @(posedge clk) begin : mon
        bit eo, eout, ed, eu, epe;
        logic [7:0] erd;
        string tg;
        #2;
        cyc++;
        if (rst_n && !finished) begin
            if (q_oe.size() > 0) begin
                eo = q_oe.pop_front();
                eout = q_out.pop_front();
                ed = q_dn.pop_front();
                eu = q_up.pop_front();
                erd = q_rd.pop_front();
                epe = q_pe.pop_front();
                tg = q_tag.pop_front();
                if (eu) begin
                    e_rd = erd;
                    e_pe = epe;
                end
            end else begin
                eo = 1'b0; eout = 1'b1; ed = 1'b0; tg = "R6";
            end
            check(tg, "line_oe", int'(line_oe), int'(eo));
            check(tg, "line_out", int'(line_out), int'(eout));
            check(tg, "done", int'(done), int'(ed));
            check("R9", "rx_data", int'(rx_data), int'(e_rd));
            check("R9", "parity_err", int'(parity_err), int'(e_pe));
        end
        if (cyc > 100000 && !finished) begin
            errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    task automatic tx_frame(logic [7:0] d, bit w, bit glitch);
        int n;
        bit p;
        bit b;
        n = w ? 8 : 7;
        p = 1'b0;
        @(negedge clk);
        for (int m = 0; m < BIT_CYC; m++) push(1, 0, 0, 0, 8'h00, 0, glitch ? "R1" : "R2");
        push(1, 1, 0, 0, 8'h00, 0, glitch ? "R1" : "R2");
        for (int k = 0; k < n; k++) begin
            b = d[(w ? 7 : 6) - k];
            p = p ^ b;
            for (int m = 0; m < BIT_CYC; m++) push(1, b, 0, 0, 8'h00, 0, glitch ? "R1" : "R3");
        end
        for (int m = 0; m < BIT_CYC; m++) push(1, p, 0, 0, 8'h00, 0, glitch ? "R1" : "R4");
        for (int m = 0; m < BIT_CYC; m++)
            push(1, 0, (m == BIT_CYC - 1), 0, 8'h00, 0,
                 glitch ? "R1" : ((m == BIT_CYC - 1) ? "R10" : "R5"));
        tx_data = d; wide = w; tx_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (glitch) begin
            repeat (20) @(negedge clk);
            start = 1'b1; tx_mode = 1'b0; wide = !w; tx_data = ~d;
            @(negedge clk);
            start = 1'b0; tx_mode = 1'b1;
        end
        while (q_oe.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic rx_frame(logic [7:0] d, bit w, int h, bit bad_par, bit tmo, bit glitch);
        int n, eoff, mdone;
        bit p;
        bit b;
        logic [7:0] erd;
        bit epe;
        string tw, tb;
        n = w ? 8 : 7;
        p = 1'b0;
        @(negedge clk);
        if (!tmo) begin
            for (int j = 0; j < h; j++) l_q.push_back(1'b1);
            for (int j = 0; j < BIT_CYC; j++) l_q.push_back(1'b0);
            l_q.push_back(1'b1);
            for (int k = 0; k < n; k++) begin
                b = d[(w ? 7 : 6) - k];
                p = p ^ b;
                for (int j = 0; j < BIT_CYC; j++) l_q.push_back(b);
            end
            for (int j = 0; j < BIT_CYC; j++) l_q.push_back(p ^ bad_par);
            for (int j = 0; j < BIT_CYC; j++) l_q.push_back(1'b0);
            eoff = 1 + h + BIT_CYC;
            erd = w ? d : {1'b0, d[6:0]};
            epe = bad_par;
        end else begin
            eoff = TMO + 1;
            erd = w ? 8'hFF : 8'h7F;
            epe = (n % 2 == 0);
        end
        tw = glitch ? "R1" : (tmo ? "R11" : "R7");
        tb = glitch ? "R1" : (tmo ? "R11" : "R8");
        mdone = eoff + HALF + 1 + n * BIT_CYC;
        for (int m = 0; m <= mdone; m++)
            push(0, 1, (m == mdone), (m == mdone), erd, epe,
                 (m == mdone) ? (glitch ? "R1" : "R9") : ((m < eoff) ? tw : tb));
        tx_mode = 1'b0; wide = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (glitch) begin
            repeat (15) @(negedge clk);
            start = 1'b1; tx_mode = 1'b1; wide = !w;
            @(negedge clk);
            start = 1'b0; tx_mode = 1'b0;
        end
        while (q_oe.size() > 0 || l_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6", "reset line_oe", int'(line_oe), 0);
        check("R6", "reset line_out", int'(line_out), 1);
        check("R6", "reset done", int'(done), 0);
        check("R6", "reset rx_data", int'(rx_data), 0);
        check("R6", "reset parity_err", int'(parity_err), 0);

        tx_frame(8'hA5, 1'b1, 1'b0);
        tx_frame(8'hDA, 1'b0, 1'b1);
        tx_frame(8'hFF, 1'b1, 1'b0);
        tx_frame(8'h00, 1'b0, 1'b0);
        rx_frame(8'hC3, 1'b1, 3, 1'b0, 1'b0, 1'b0);
        rx_frame(8'h55, 1'b0, 0, 1'b1, 1'b0, 1'b0);
        rx_frame(8'h00, 1'b1, 0, 1'b0, 1'b1, 1'b0);
        rx_frame(8'h01, 1'b1, 10, 1'b0, 1'b0, 1'b1);
        tx_frame(8'h3C, 1'b1, 1'b0);
        finish_run();
    end

endmodule